// File: doc/BRIEF.md
# Memory-Module Configuration EEPROM Target

This block is the bus-side model of the small configuration store that sits on a memory module. It answers on a two-wire serial bus (clock and data, open-drain), holds a 256-byte image that a host can read and rewrite, and reports a 16-bit temperature word supplied from elsewhere on the chip. Three strap inputs give the module its slot number. Up to eight such targets can then sit on one shared clock/data pair, each with a distinct address.

The strap value is the low three bits of three separate 7-bit addresses. The storage group is `0x50 | strap`. The protection group is `0x30 | strap`, and it answers only until protection has been switched on. The temperature group is `0x18 | strap`. All bus inputs are oversampled by the core clock, which must run well above the serial clock. The only data path is the serial line, so there is no valid/ready interface and no back-pressure at the chip side. The temperature word is a plain level input, sampled once when its address is accepted. The target never stretches the clock.

Top module: `spd_target`

## Requirements
- R1: After an address byte (7-bit address in bits 7:1, bit 0 = 1 for read, 0 for write), the target pulls the data line low in the acknowledge slot only when the address equals `0x50 | strap` or `0x18 | strap`, or equals `0x30 | strap` while unprotected. Any other address leaves the line released for the rest of that transfer.
- R2: A read at `0x18 | strap` returns the upper byte of the temperature word, then the lower byte, and keeps alternating upper/lower for as long as the host acknowledges.
- R3: A write-direction address byte to `0x30 | strap` is acknowledged and sets a protect flag. The flag stays set until reset, and from then on that address is not acknowledged.
- R4: While the protect flag is set, data bytes written to the storage group are still acknowledged but leave the stored image unchanged.
- R5: In a storage write, the first byte after the address loads the byte pointer. Each later byte is stored at the pointer, after which the pointer increments modulo 256 (0xFF is followed by 0x00).
- R6: In a storage read, each byte sent is the image byte at the pointer, and the pointer then increments modulo 256. Sending continues while the host acknowledges. After a host not-acknowledge the target releases the line.
- R7: A start condition at any point, including partway through a byte, drops the byte being received without storing it and restarts address matching. The pointer keeps the value from the last completed byte.
- R8: The target changes its data-line drive only while the serial clock is low. After reset, and whenever it is idle, it leaves the line released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock as seen on the pad |
| sda_i | input | 1 | Serial data as seen on the pad (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| strap_i | input | STRAP_W (3) | Slot strap, low bits of all three addresses |
| temp_value_i | input | 16 | Temperature register value reported in the sensor group |

## Verification
The checks assume that every high and low phase of the serial clock spans at least four core cycles. They also assume that the host moves the data line only while the clock is low, except when it forms a start or stop condition. Finally, they assume that the host never signals start or stop while the target is driving a data or acknowledge bit. Under these conditions the target's drive changes, which come three core cycles after a clock fall, always land inside the low phase. The bench drives the bus with quarter-bit steps of four core cycles and changes data only one quarter after each clock fall. It aborts a byte only during a host-driven write byte.

// File: rtl/spd_pkg.sv
package spd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_RX,
    ST_TX,
    ST_MACK
  } spd_state_e;

  typedef enum logic [1:0] {
    GRP_NONE,
    GRP_MEM,
    GRP_PROT,
    GRP_TEMP
  } spd_grp_e;
endpackage

// File: rtl/spd_bus_sense.sv
module spd_bus_sense #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_s, scl_d, sda_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_p[g] <= 1'b1;
          sda_p[g] <= 1'b1;
        end else begin
          scl_p[g] <= scl_i;
          sda_p[g] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_p[g] <= 1'b1;
          sda_p[g] <= 1'b1;
        end else begin
          scl_p[g] <= scl_p[g-1];
          sda_p[g] <= sda_p[g-1];
        end
      end
    end
  end

  assign scl_s = scl_p[STAGES-1];
  assign sda_s = sda_p[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/spd_addr_decode.sv
module spd_addr_decode
  import spd_pkg::*;
#(
  parameter int         STRAP_W   = 3,
  parameter logic [6:0] MEM_BASE  = 7'h50,
  parameter logic [6:0] PROT_BASE = 7'h30,
  parameter logic [6:0] TEMP_BASE = 7'h18,
  parameter bit         TEMP_EN   = 1'b1
) (
  input  logic [6:0]         addr,
  input  logic [STRAP_W-1:0] strap,
  input  logic               prot,
  output spd_grp_e           grp
);
  logic slot_ok, hit_mem, hit_prot, hit_temp;

  assign slot_ok  = (addr[STRAP_W-1:0] == strap);
  assign hit_mem  = slot_ok && (addr[6:STRAP_W] == MEM_BASE[6:STRAP_W]);
  assign hit_prot = slot_ok && !prot && (addr[6:STRAP_W] == PROT_BASE[6:STRAP_W]);

  if (TEMP_EN) begin : g_temp
    assign hit_temp = slot_ok && (addr[6:STRAP_W] == TEMP_BASE[6:STRAP_W]);
  end else begin : g_no_temp
    assign hit_temp = 1'b0;
  end

  always_comb begin
    if (hit_mem)       grp = GRP_MEM;
    else if (hit_prot) grp = GRP_PROT;
    else if (hit_temp) grp = GRP_TEMP;
    else               grp = GRP_NONE;
  end
endmodule

// File: rtl/spd_byte_store.sv
module spd_byte_store #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/spd_target.sv
module spd_target
  import spd_pkg::*;
#(
  parameter int STRAP_W     = 3,
  parameter int PTR_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit TEMP_EN     = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [15:0]        temp_value_i
);
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  spd_state_e          st_q;
  spd_grp_e            grp_q, grp_w;
  logic [CNT_W-1:0]    cnt_q;
  logic [BYTE_W-1:0]   sh_q, tx_q, load_byte, rd_data;
  logic [PTR_W-1:0]    ptr_q;
  logic [15:0]         temp_q;
  logic                rw_q, ptr_pend_q, wp_q, tsel_q, mack_q;
  logic                byte_done, load_now, mem_we, in_idle;

  spd_bus_sense #(.STAGES(SYNC_STAGES)) sense_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  spd_addr_decode #(.STRAP_W(STRAP_W), .TEMP_EN(TEMP_EN)) dec_i (
    .addr(sh_q[7:1]), .strap(strap_i), .prot(wp_q), .grp(grp_w)
  );

  spd_byte_store #(.AW(PTR_W), .DW(BYTE_W)) store_i (
    .clk(clk), .we(mem_we), .waddr(ptr_q), .wdata(sh_q),
    .raddr(ptr_q), .rdata(rd_data)
  );

  always_comb begin
    case (grp_q)
      GRP_MEM:  load_byte = rd_data;
      GRP_TEMP: load_byte = tsel_q ? temp_q[7:0] : temp_q[15:8];
      default:  load_byte = '1;
    endcase
  end

  assign byte_done = scl_fall && (cnt_q == CNT_FULL);
  assign load_now  = scl_fall && !start_det && !stop_det &&
                     (((st_q == ST_ACK) && rw_q) || ((st_q == ST_MACK) && mack_q));
  assign mem_we    = !start_det && !stop_det && (st_q == ST_RX) && byte_done &&
                     (grp_q == GRP_MEM) && !ptr_pend_q && !wp_q;
  assign in_idle   = (st_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      grp_q      <= GRP_NONE;
      cnt_q      <= '0;
      sh_q       <= '0;
      tx_q       <= '0;
      ptr_q      <= '0;
      temp_q     <= '0;
      rw_q       <= 1'b0;
      ptr_pend_q <= 1'b0;
      wp_q       <= 1'b0;
      tsel_q     <= 1'b0;
      mack_q     <= 1'b0;
      sda_oe     <= 1'b0;
    end else if (start_det) begin
      st_q   <= ST_ADDR;
      cnt_q  <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      st_q   <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st_q)
        ST_ADDR: begin
          if (scl_rise && cnt_q != CNT_FULL) begin
            sh_q  <= {sh_q[BYTE_W-2:0], sda_s};
            cnt_q <= cnt_q + 1'b1;
          end else if (byte_done) begin
            if (grp_w == GRP_NONE) begin
              st_q <= ST_IDLE;
            end else begin
              st_q       <= ST_ACK;
              sda_oe     <= 1'b1;
              grp_q      <= grp_w;
              rw_q       <= sh_q[0];
              ptr_pend_q <= (grp_w == GRP_MEM) && !sh_q[0];
              temp_q     <= temp_value_i;
              tsel_q     <= 1'b0;
              if (grp_w == GRP_PROT && !sh_q[0]) wp_q <= 1'b1;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt_q <= '0;
            if (rw_q) begin
              st_q   <= ST_TX;
              tx_q   <= load_byte;
              sda_oe <= ~load_byte[BYTE_W-1];
            end else begin
              st_q   <= ST_RX;
              sda_oe <= 1'b0;
            end
          end
        end
        ST_RX: begin
          if (scl_rise && cnt_q != CNT_FULL) begin
            sh_q  <= {sh_q[BYTE_W-2:0], sda_s};
            cnt_q <= cnt_q + 1'b1;
          end else if (byte_done) begin
            st_q   <= ST_ACK;
            sda_oe <= 1'b1;
            if (grp_q == GRP_MEM) begin
              if (ptr_pend_q) begin
                ptr_q      <= sh_q[PTR_W-1:0];
                ptr_pend_q <= 1'b0;
              end else begin
                ptr_q <= ptr_q + 1'b1;
              end
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == CNT_LAST) begin
              st_q   <= ST_MACK;
              sda_oe <= 1'b0;
              mack_q <= 1'b0;
            end else begin
              cnt_q  <= cnt_q + 1'b1;
              tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
              sda_oe <= ~tx_q[BYTE_W-2];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_q <= !sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              st_q   <= ST_TX;
              cnt_q  <= '0;
              tx_q   <= load_byte;
              sda_oe <= ~load_byte[BYTE_W-1];
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
      if (load_now) begin
        if (grp_q == GRP_MEM)  ptr_q  <= ptr_q + 1'b1;
        if (grp_q == GRP_TEMP) tsel_q <= ~tsel_q;
      end
    end
  end
endmodule

// File: rtl/spd_target_chk.sv
module spd_target_chk #(
  parameter int PTR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_i,
  input logic             sda_oe,
  input logic             in_idle,
  input logic             wp_q,
  input logic             mem_we,
  input logic [PTR_W-1:0] ptr_q
);
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i); // R8

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_oe); // R8

  AST_PROTECT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wp_q |=> wp_q); // R3

  AST_PROTECT_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    wp_q |-> !mem_we); // R4

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (ptr_q == $past(ptr_q) + PTR_W'(1))); // R5
endmodule

bind spd_target spd_target_chk #(.PTR_W(PTR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .in_idle(in_idle), .wp_q(wp_q), .mem_we(mem_we), .ptr_q(ptr_q)
);

// File: tb/spd_target_tb.sv
`timescale 1ns/1ps
module spd_target_tb_top;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe;
  logic [2:0] strap = 3'd5;
  logic [15:0] temp_val = 16'h0000;
  logic sda_line;
  int checks = 0;
  int fails = 0;
  logic [7:0] model [256];

  always #2 clk = ~clk;

  assign sda_line = ~(m_low | sda_oe);

  spd_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .strap_i(strap), .temp_value_i(temp_val)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; wq(1); scl = 1'b1; wq(1); m_low = 1'b1; wq(1); scl = 1'b0; wq(1);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wq(1); scl = 1'b1; wq(1); m_low = 1'b0; wq(1);
  endtask

  task automatic send_bit(input bit v);
    m_low = !v; wq(1); scl = 1'b1; wq(2); scl = 1'b0; wq(1);
  endtask

  task automatic recv_bit(output bit v);
    m_low = 1'b0; wq(1); scl = 1'b1; wq(1); v = sda_line; wq(1); scl = 1'b0; wq(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    bit x;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    recv_bit(x);
    acked = !x;
  endtask

  task automatic recv_byte(input bit last, output logic [7:0] d);
    bit x;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(x);
      d[i] = x;
    end
    send_bit(last);
  endtask

  task automatic probe(input logic [6:0] a, output bit acked);
    bus_start();
    send_byte({a, 1'b0}, acked);
    bus_stop();
  endtask

  // Read n bytes starting at ptr from storage and compare with model
  task automatic read_check(input logic [7:0] ptr, input int n, input string req);
    bit a;
    logic [7:0] d;
    bus_start();
    send_byte({4'b1010, strap, 1'b0}, a);
    send_byte(ptr, a);
    bus_start();
    send_byte({4'b1010, strap, 1'b1}, a);
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n - 1, d);
      chk(d === model[8'(ptr + i)], req, d, model[8'(ptr + i)]);
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit a;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R8: released after reset
    chk(sda_oe == 1'b0, "R8 reset release", sda_oe, 0);

    // R1 / R2: address sweep over every strap value
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      for (int k = 0; k < 8; k++) begin
        probe(7'h50 + 7'(k), a);
        chk(a == (k == s), "R1 storage match", a, k == s);
        probe(7'h18 + 7'(k), a);
        chk(a == (k == s), "R2 sensor match", a, k == s);
      end
    end
    strap = 3'd5;
    chk(sda_oe == 1'b0, "R1 released after mismatch", sda_oe, 0);

    // R5 / R6: full image write from pointer 0, then full read
    bus_start();
    send_byte({4'b1010, strap, 1'b0}, a);
    send_byte(8'h00, a);
    for (int i = 0; i < 256; i++) begin
      model[i] = 8'((i * 37 + 11) & 255);
      send_byte(model[i], a);
      if (i == 0 || i == 255) chk(a, "R5 data ack", a, 1);
    end
    bus_stop();
    read_check(8'h00, 256, "R6 sequential read");
    wq(2);
    chk(sda_oe == 1'b0, "R6 release after nack", sda_oe, 0);

    // R5: pointer wrap on write and R6 on read
    bus_start();
    send_byte({4'b1010, strap, 1'b0}, a);
    send_byte(8'hFE, a);
    send_byte(8'h11, a); model[8'hFE] = 8'h11;
    send_byte(8'h22, a); model[8'hFF] = 8'h22;
    send_byte(8'h33, a); model[8'h00] = 8'h33;
    bus_stop();
    read_check(8'hFE, 4, "R5 wrap");

    // R7: start partway through a data byte
    bus_start();
    send_byte({4'b1010, strap, 1'b0}, a);
    send_byte(8'h40, a);
    send_byte(8'hA5, a); model[8'h40] = 8'hA5;
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_start();
    send_byte({4'b1010, strap, 1'b1}, a);
    chk(a, "R7 address after abort", a, 1);
    recv_byte(1'b1, d);
    chk(d === model[8'h41], "R7 partial byte dropped", d, model[8'h41]);
    bus_stop();
    read_check(8'h40, 2, "R7 completed byte kept");

    // R2: sensor word, upper then lower, alternating
    temp_val = 16'hBEEF;
    bus_start();
    send_byte({4'b0011, strap, 1'b1}, a);
    chk(a, "R2 sensor ack", a, 1);
    recv_byte(1'b0, d); chk(d == 8'hBE, "R2 upper byte", d, 8'hBE);
    recv_byte(1'b0, d); chk(d == 8'hEF, "R2 lower byte", d, 8'hEF);
    recv_byte(1'b1, d); chk(d == 8'hBE, "R2 alternate", d, 8'hBE);
    bus_stop();

    // R3: protection group, wrong slot then right slot, then sticky
    probe(7'h32, a);
    chk(!a, "R3 other slot nack", a, 0);
    probe(7'h35, a);
    chk(a, "R3 protect ack", a, 1);
    probe(7'h35, a);
    chk(!a, "R3 nack once protected", a, 0);

    // R4: writes acknowledged but discarded
    bus_start();
    send_byte({4'b1010, strap, 1'b0}, a);
    chk(a, "R4 storage still acks", a, 1);
    send_byte(8'h10, a);
    send_byte(8'h99, a);
    chk(a, "R4 data ack while protected", a, 1);
    bus_stop();
    read_check(8'h10, 1, "R4 image unchanged");
    probe(7'h35, a);
    chk(!a, "R3 still protected", a, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule